// File: doc/BRIEF.md
# Load Reservation Monitor

This block holds the single reservation used by an atomic load-and-reserve / store-conditional pair. When a load-and-reserve completes, the block records its address and marks the reservation live. A later store-conditional asks the block whether it may commit. The block answers one cycle later with a done strobe and a pass/fail flag. Every store-conditional consumes the reservation, whatever its outcome.

A live reservation can be lost in two ways. The first is an internal snoop hit: the companion communication engine touches the reserved word on the on-chip bus. The second is a pulse on either of two dedicated cancel inputs. Traffic on the off-chip bus is not watched, so it has no path into the block. Addresses are compared at word granularity: the low `WORD_LSB` bits are ignored.

Top module: `resv_monitor`

## Requirements
- R1: With `rst_n` low at a clock edge, the reservation is cleared. After reset, `resv_active` is 0 and a store-conditional fails.
- R2: A load-and-reserve (`lr_valid` high at an edge) makes `resv_active` read 1 from the following cycle and records `lr_addr`.
- R3: A store-conditional (`sc_valid` high at an edge) passes when the reservation is live and `sc_addr` equals the recorded address in bits [31:2]. Bits [1:0] are ignored. The result appears the cycle after the request as `sc_done`=1 with `sc_pass`=1.
- R4: A store-conditional with no live reservation, or with a different word address, gives `sc_done`=1 and `sc_pass`=0 in the cycle after the request.
- R5: Every store-conditional, whether it passes or fails, leaves the reservation cleared.
- R6: A new load-and-reserve replaces the recorded address. Afterwards only the new word passes.
- R7: A snoop (`snp_valid`) whose word address matches a live reservation clears it. A snoop to any other word leaves the reservation intact.
- R8: A high level on `cancel_a` or `cancel_b` at an edge clears the reservation.
- R9: If a snoop hit or a cancel coincides with a store-conditional, that store-conditional fails.
- R10: If a load-and-reserve coincides with a store-conditional, a cancel or a snoop hit, the store-conditional is judged against the old reservation. The new reservation is live afterwards.
- R11: In a cycle following one with `sc_valid` low, `sc_done` and `sc_pass` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_valid | input | 1 | Load-and-reserve completes this cycle |
| lr_addr | input | ADDR_W | Load-and-reserve address |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_addr | input | ADDR_W | Store-conditional address |
| snp_valid | input | 1 | Communication-engine access on the internal bus |
| snp_addr | input | ADDR_W | Address of that access |
| cancel_a | input | 1 | First external reservation cancel |
| cancel_b | input | 1 | Second external reservation cancel |
| sc_done | output | 1 | Store-conditional result valid |
| sc_pass | output | 1 | Store-conditional may commit |
| resv_active | output | 1 | Reservation currently live |

## Verification
The bench targets several same-cycle collisions. A cancel or snoop hit coinciding with a store-conditional must fail it; a design that resolved the clear first would still fail it, but one that sampled the old state would wrongly pass. A load-and-reserve colliding with a clear must keep the new reservation; getting that priority backwards leaves the reservation dead.

Byte offsets within a word are also exercised. A design comparing full addresses would fail legitimate store-conditionals. A design comparing too few bits would let a neighbouring-word snoop kill the reservation. Failed store-conditionals are followed by a retry to the reserved word, which exposes a design that clears only on success.

// File: rtl/resv_pkg.sv
// Package: shared defaults and the result encoding for the reservation monitor.
// Assumes byte addressing with a word size of 2**RESV_WORD_LSB bytes.
package resv_pkg;
    localparam int RESV_ADDR_W   = 32;
    localparam int RESV_WORD_LSB = 2;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_FAIL = 2'b10,
        SC_PASS = 2'b11
    } sc_res_e;
endpackage

// File: rtl/resv_word_match.sv
// Module: word-granular address comparator.
// Reports a hit when two byte addresses fall in the same word; the low
// WORD_LSB bits are masked off. Purely combinational.
module resv_word_match #(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << WORD_LSB;

    // compare only the word-selecting bits
    always_comb begin
        hit = (((addr_a ^ addr_b) & WORD_MASK) == '0);
    end
endmodule

// File: rtl/resv_store.sv
// Module: reservation register.
// Holds one address plus a live flag. A set request wins over a clear in
// the same cycle, so a fresh load-and-reserve survives any collision.
// Assumes set and clr are single-cycle qualified strobes.
module resv_store #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr,
    output logic              live,
    output logic [ADDR_W-1:0] addr
);
    // update the live flag: set beats clear, reset empties it
    always_ff @(posedge clk) begin
        if (!rst_n)   live <= 1'b0;
        else if (set) live <= 1'b1;
        else if (clr) live <= 1'b0;
    end

    // capture the address of each load-and-reserve
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (set) addr <= set_addr;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !live);
    // R2
    set_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> live);
    // R5
    clr_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !live);
endmodule

// File: rtl/resv_sc_judge.sv
// Module: store-conditional verdict register.
// Registers a one-cycle result for each request. A request passes only if
// the reservation is live, the word matches, and no kill event lands in
// the same cycle. Assumes hit is already qualified against the stored address.
module resv_sc_judge
    import resv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic live,
    input  logic hit,
    input  logic kill,
    output logic done,
    output logic pass
);
    sc_res_e res_d, res_q;

    // decide the verdict for this cycle's request
    always_comb begin
        if (!req)                      res_d = SC_NONE;
        else if (live && hit && !kill) res_d = SC_PASS;
        else                           res_d = SC_FAIL;
    end

    // hold the verdict for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= SC_NONE;
        else        res_q <= res_d;
    end

    // split the encoding onto the two result flags
    always_comb begin
        done = res_q[1];
        pass = res_q[0];
    end

    // R3
    pass_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!done && !pass));
    // R9
    kill_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && kill) |=> (done && !pass));
    // R4
    dead_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !live) |=> !pass);
endmodule

// File: rtl/resv_monitor.sv
// Module: load reservation monitor (top).
// Tracks the single reservation for the load-and-reserve / store-conditional
// pair and judges each store-conditional. The reservation is lost through
// internal snoop hits, through either cancel input, or through any
// store-conditional. Off-chip bus traffic has no input.
// Assumes all request strobes are synchronous to clk.
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W   = RESV_ADDR_W,
    parameter int WORD_LSB = RESV_WORD_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              cancel_a,
    input  logic              cancel_b,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              resv_active
);
    logic              live;
    logic [ADDR_W-1:0] held_addr;
    logic              sc_hit, snp_hit;
    logic              kill, clr;

    resv_word_match #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_sc_match (
        .addr_a(sc_addr), .addr_b(held_addr), .hit(sc_hit));

    resv_word_match #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_snp_match (
        .addr_a(snp_addr), .addr_b(held_addr), .hit(snp_hit));

    // gather every event that destroys the reservation this cycle
    always_comb begin
        kill = cancel_a || cancel_b || (snp_valid && live && snp_hit);
        clr  = kill || sc_valid;
    end

    resv_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .set(lr_valid), .set_addr(lr_addr),
        .clr(clr), .live(live), .addr(held_addr));

    resv_sc_judge u_judge (
        .clk(clk), .rst_n(rst_n), .req(sc_valid), .live(live), .hit(sc_hit),
        .kill(kill), .done(sc_done), .pass(sc_pass));

    // expose the live flag
    always_comb resv_active = live;

    // R8
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cancel_a || cancel_b) && !lr_valid) |=> !resv_active);
    // R10
    lr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_valid && (sc_valid || cancel_a || cancel_b)) |=> resv_active);
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lr_valid = 1'b0, sc_valid = 1'b0, snp_valid = 1'b0;
    logic [AW-1:0] lr_addr = '0, sc_addr = '0, snp_addr = '0;
    logic          cancel_a = 1'b0, cancel_b = 1'b0;
    logic          sc_done, sc_pass, resv_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    resv_monitor uut (
        .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .cancel_a(cancel_a), .cancel_b(cancel_b),
        .sc_done(sc_done), .sc_pass(sc_pass), .resv_active(resv_active));

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // advance one edge; inputs were applied away from the edge
    task automatic tick();
        @(posedge clk);
        #1;
        lr_valid = 0; sc_valid = 0; snp_valid = 0; cancel_a = 0; cancel_b = 0;
    endtask

    task automatic do_lr(input logic [AW-1:0] a);
        lr_valid = 1; lr_addr = a;
        tick();
    endtask

    task automatic do_sc(input logic [AW-1:0] a, input logic exp, input string req);
        sc_valid = 1; sc_addr = a;
        tick();
        check(req, sc_done, 1'b1);
        check(req, sc_pass, exp);
        check("R5", resv_active, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        tick(); tick();
        check("R1", resv_active, 1'b0);
        check("R11", sc_done, 1'b0);
        rst_n = 1;
        tick();
        do_sc(32'h100, 1'b0, "R1");
        // reset drops a live reservation
        do_lr(32'h200);
        rst_n = 0; tick(); rst_n = 1;
        check("R1", resv_active, 1'b0);
        do_sc(32'h200, 1'b0, "R1");
    endtask

    task automatic t_basic();
        do_lr(32'h1000);
        check("R2", resv_active, 1'b1);
        check("R11", sc_pass, 1'b0);
        do_sc(32'h1003, 1'b1, "R3");
        do_sc(32'h1000, 1'b0, "R5");
        do_lr(32'h1000);
        do_sc(32'h1004, 1'b0, "R4");
        do_sc(32'h1000, 1'b0, "R5");
    endtask

    task automatic t_replace();
        do_lr(32'h2000);
        do_lr(32'h3008);
        check("R6", resv_active, 1'b1);
        do_sc(32'h2000, 1'b0, "R6");
        do_lr(32'h2000);
        do_lr(32'h3008);
        do_sc(32'h300A, 1'b1, "R6");
    endtask

    task automatic t_snoop();
        do_lr(32'h4000);
        snp_valid = 1; snp_addr = 32'h4004; tick();
        check("R7", resv_active, 1'b1);
        snp_valid = 1; snp_addr = 32'h4002; tick();
        check("R7", resv_active, 1'b0);
        do_sc(32'h4000, 1'b0, "R7");
        do_lr(32'h4000);
        snp_valid = 1; snp_addr = 32'h8000; tick();
        do_sc(32'h4001, 1'b1, "R7");
    endtask

    task automatic t_cancel();
        do_lr(32'h5000);
        cancel_a = 1; tick();
        check("R8", resv_active, 1'b0);
        do_sc(32'h5000, 1'b0, "R8");
        do_lr(32'h5000);
        cancel_b = 1; tick();
        check("R8", resv_active, 1'b0);
        do_sc(32'h5000, 1'b0, "R8");
    endtask

    task automatic t_collide();
        do_lr(32'h6000);
        cancel_b = 1; do_sc(32'h6000, 1'b0, "R9");
        do_lr(32'h6000);
        snp_valid = 1; snp_addr = 32'h6003; do_sc(32'h6000, 1'b0, "R9");
        do_lr(32'h6000);
        snp_valid = 1; snp_addr = 32'h7000; do_sc(32'h6000, 1'b1, "R9");
        // LR with SC: SC judged on old reservation, new one survives
        do_lr(32'h6000);
        lr_valid = 1; lr_addr = 32'h6100; sc_valid = 1; sc_addr = 32'h6000;
        tick();
        check("R10", sc_pass, 1'b1);
        check("R10", resv_active, 1'b1);
        do_sc(32'h6100, 1'b1, "R10");
        lr_valid = 1; lr_addr = 32'h6200; cancel_a = 1; tick();
        check("R10", resv_active, 1'b1);
        do_sc(32'h6200, 1'b1, "R10");
        tick();
        check("R11", sc_done, 1'b0);
        check("R11", sc_pass, 1'b0);
    endtask

    initial begin
        #5;
        t_reset();
        t_basic();
        t_replace();
        t_snoop();
        t_cancel();
        t_collide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule